// File: doc/BRIEF.md
# Critical-Word-First Write-Back Data Cache

A direct-mapped write-back data cache whose lines hold several words under one shared tag. Validity and dirtiness are kept for every word, not for the whole line, so a line can be partly present while it is being refilled. A sequential scan therefore goes to memory only once per line.

When a request misses, the victim line's changed words are written back first, and only those words. Then the new line is fetched one word at a time. The fetch starts at the word the stalled request asked for and wraps around the line. The stalled request completes in the same cycle its word arrives. While the rest of the line streams in, requests to words of that line that have already arrived are served at once. Any other request waits until the line is complete.

The processor side is a hold-until-acknowledge request port with a combinational `ack_o`. The memory side issues one word-addressed request at a time and holds it until `mem_ack_i`.

Top module: `cwf_cache`

## Requirements
- R1: After reset no word is valid and `ack_o` and `mem_req_o` are low. The first access to any address goes to memory.
- R2: `addr_i` is a word address. Bits [1:0] select the word in the line, bits [7:2] select one of 64 lines, and the bits above form the tag. A read that hits raises `ack_o` in the cycle it is presented, returns the stored word and makes no memory request.
- R3: A refill for a request to word k reads words k, k+1, k+2, k+3 (mod 4) of the new line, in that order. Each request is held with a stable address until `mem_ack_i`.
- R4: A stalled request is acknowledged in the cycle `mem_ack_i` returns its own word. A read receives `mem_rdata_i` in that cycle.
- R5: During a refill, a request to a word of the refilling line that has already arrived hits. A request to any other line, or to a word not yet arrived, waits until the refill ends.
- R6: A write hit replaces the word, marks it changed, and a later read returns the new value.
- R7: A write miss allocates the line. The refill starts at the written word, and the written data survives the refill as a changed word.
- R8: On a miss to a line holding changed words, each changed word is written to the old line's address, in ascending word order, before any read of the new line. Unchanged words are not written.
- R9: A miss whose victim holds no changed word makes no memory write.
- R10: `ack_o` is raised only while `req_i` is high.
- R11: While changed words are being written back, no request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until `ack_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 16 | Word address |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | Access completes this cycle |
| rdata_o | output | 32 | Read data, valid with `ack_o` |
| mem_req_o | output | 1 | Memory word request |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory accepts the request; read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The hardest situation to reach from the ports is a request arriving while a refill is only partly done. Such a request either hits a word that has already landed or stalls on one that has not, and which one happens depends on the memory latency. The bench issues a second request in the cycle after the critical word is acknowledged. It then records how many memory transfers had completed when that second request was acknowledged. This separates a same-line early hit, a stall on the last word in wrap order, and a stall on a different line. Write-back ordering is reached by dirtying chosen words and then evicting the line with a conflicting tag, while random memory latency shifts every beat.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_FILL = 2'd2
  } cwf_state_e;
endpackage

// File: rtl/cwf_pick_low.sv
// Lowest set bit of a mask.
module cwf_pick_low #(
  parameter int N = 4,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] mask_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/cwf_line_store.sv
// Tag, data and per-word valid/dirty arrays.
module cwf_line_store #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 64,
  parameter int TAG_W  = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  // request-side read port
  input  logic [IDX_W-1:0]              ra_idx_i,
  output logic [TAG_W-1:0]              ra_tag_o,
  output logic [WORDS-1:0]              ra_valid_o,
  output logic [WORDS-1:0][DATA_W-1:0]  ra_data_o,
  // victim read port
  input  logic [IDX_W-1:0]              rb_idx_i,
  output logic [TAG_W-1:0]              rb_tag_o,
  output logic [WORDS-1:0]              rb_dirty_o,
  output logic [WORDS-1:0][DATA_W-1:0]  rb_data_o,
  // hit write
  input  logic                          hw_en_i,
  input  logic [IDX_W-1:0]              hw_idx_i,
  input  logic [OFF_W-1:0]              hw_off_i,
  input  logic [DATA_W-1:0]             hw_data_i,
  // refill write
  input  logic                          fw_en_i,
  input  logic [IDX_W-1:0]              fw_idx_i,
  input  logic [OFF_W-1:0]              fw_off_i,
  input  logic [DATA_W-1:0]             fw_data_i,
  input  logic                          fw_dirty_i,
  // dirty clear after writeback beat
  input  logic                          cd_en_i,
  input  logic [IDX_W-1:0]              cd_idx_i,
  input  logic [OFF_W-1:0]              cd_off_i,
  // allocate: new tag, drop all words
  input  logic                          al_en_i,
  input  logic [IDX_W-1:0]              al_idx_i,
  input  logic [TAG_W-1:0]              al_tag_i
);
  logic [TAG_W-1:0]             tag_q   [LINES];
  logic [WORDS-1:0]             val_q   [LINES];
  logic [WORDS-1:0]             dirty_q [LINES];
  logic [WORDS-1:0][DATA_W-1:0] data_q  [LINES];

  assign ra_tag_o   = tag_q[ra_idx_i];
  assign ra_valid_o = val_q[ra_idx_i];
  assign ra_data_o  = data_q[ra_idx_i];
  assign rb_tag_o   = tag_q[rb_idx_i];
  assign rb_dirty_o = dirty_q[rb_idx_i];
  assign rb_data_o  = data_q[rb_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < LINES; l++) begin
        val_q[l]   <= '0;
        dirty_q[l] <= '0;
      end
    end else begin
      if (al_en_i) begin
        val_q[al_idx_i]   <= '0;
        dirty_q[al_idx_i] <= '0;
      end
      if (cd_en_i) dirty_q[cd_idx_i][cd_off_i] <= 1'b0;
      if (fw_en_i) begin
        val_q[fw_idx_i][fw_off_i]   <= 1'b1;
        dirty_q[fw_idx_i][fw_off_i] <= fw_dirty_i;
      end
      if (hw_en_i) dirty_q[hw_idx_i][hw_off_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (al_en_i) tag_q[al_idx_i] <= al_tag_i;
    if (fw_en_i) data_q[fw_idx_i][fw_off_i] <= fw_data_i;
    if (hw_en_i) data_q[hw_idx_i][hw_off_i] <= hw_data_i;
  end
endmodule

// File: rtl/cwf_cache.sv
module cwf_cache #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int LINES  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import cwf_pkg::*;

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(WORDS - 1);

  logic [OFF_W-1:0] req_off;
  logic [IDX_W-1:0] req_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_off = addr_i[OFF_W-1:0];
  assign req_idx = addr_i[OFF_W +: IDX_W];
  assign req_tag = addr_i[ADDR_W-1 -: TAG_W];

  cwf_state_e       state_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic [OFF_W-1:0] miss_off_q;
  logic             miss_we_q;
  logic [DATA_W-1:0] miss_wdata_q;
  logic [OFF_W-1:0] fill_cnt_q;

  logic [TAG_W-1:0]             ra_tag, rb_tag;
  logic [WORDS-1:0]             ra_valid, rb_dirty;
  logic [WORDS-1:0][DATA_W-1:0] ra_data, rb_data;

  logic             tag_hit, hit_ok, fill_beat, crit_beat;
  logic             wb_any, wb_beat, alloc;
  logic [OFF_W-1:0] wb_off, fill_off;

  assign tag_hit   = (ra_tag == req_tag) && ra_valid[req_off];
  // same-line early hits allowed only while that line refills
  assign hit_ok    = req_i && tag_hit &&
                     ((state_q == ST_IDLE) ||
                      ((state_q == ST_FILL) && (req_idx == miss_idx_q)));
  assign fill_off  = miss_off_q + fill_cnt_q;
  assign fill_beat = (state_q == ST_FILL) && mem_ack_i;
  assign crit_beat = fill_beat && (fill_cnt_q == '0);
  assign wb_beat   = (state_q == ST_WB) && wb_any && mem_ack_i;
  assign alloc     = (state_q == ST_WB) && !wb_any;

  assign ack_o   = hit_ok || crit_beat;
  assign rdata_o = crit_beat ? mem_rdata_i : ra_data[req_off];

  assign mem_req_o   = ((state_q == ST_WB) && wb_any) || (state_q == ST_FILL);
  assign mem_we_o    = (state_q == ST_WB);
  assign mem_addr_o  = (state_q == ST_WB) ? {rb_tag, miss_idx_q, wb_off}
                                          : {miss_tag_q, miss_idx_q, fill_off};
  assign mem_wdata_o = rb_data[wb_off];

  cwf_pick_low #(.N(WORDS), .W(OFF_W)) i_pick (
    .mask_i (rb_dirty),
    .any_o  (wb_any),
    .idx_o  (wb_off)
  );

  cwf_line_store #(
    .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES), .TAG_W(TAG_W)
  ) i_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ra_idx_i   (req_idx),
    .ra_tag_o   (ra_tag),
    .ra_valid_o (ra_valid),
    .ra_data_o  (ra_data),
    .rb_idx_i   (miss_idx_q),
    .rb_tag_o   (rb_tag),
    .rb_dirty_o (rb_dirty),
    .rb_data_o  (rb_data),
    .hw_en_i    (hit_ok && we_i),
    .hw_idx_i   (req_idx),
    .hw_off_i   (req_off),
    .hw_data_i  (wdata_i),
    .fw_en_i    (fill_beat),
    .fw_idx_i   (miss_idx_q),
    .fw_off_i   (fill_off),
    .fw_data_i  ((crit_beat && miss_we_q) ? miss_wdata_q : mem_rdata_i),
    .fw_dirty_i (crit_beat && miss_we_q),
    .cd_en_i    (wb_beat),
    .cd_idx_i   (miss_idx_q),
    .cd_off_i   (wb_off),
    .al_en_i    (alloc),
    .al_idx_i   (miss_idx_q),
    .al_tag_i   (miss_tag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      miss_idx_q   <= '0;
      miss_tag_q   <= '0;
      miss_off_q   <= '0;
      miss_we_q    <= 1'b0;
      miss_wdata_q <= '0;
      fill_cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_i && !tag_hit) begin
            state_q      <= ST_WB;
            miss_idx_q   <= req_idx;
            miss_tag_q   <= req_tag;
            miss_off_q   <= req_off;
            miss_we_q    <= we_i;
            miss_wdata_q <= wdata_i;
          end
        end
        ST_WB: begin
          if (!wb_any) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
          end
        end
        ST_FILL: begin
          if (mem_ack_i) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
            if (fill_cnt_q == LAST_BEAT) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cwf_cache_chk.sv
module cwf_cache_chk #(
  parameter int ADDR_W = 16,
  parameter int WORDS  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ack_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i
);
  localparam int OFF_W = $clog2(WORDS);

  logic [ADDR_W-1:0] nxt_addr;
  assign nxt_addr = {mem_addr_o[ADDR_W-1:OFF_W], mem_addr_o[OFF_W-1:0] + OFF_W'(1)};

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

  // R3
  fill_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_ack_i |=>
      !(mem_req_o && !mem_we_o) || (mem_addr_o == $past(nxt_addr)));

  // R8
  wb_before_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |=> !(mem_req_o && mem_we_o));

  // R11
  wb_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !ack_o);

  // R10
  ack_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> req_i);
endmodule

bind cwf_cache cwf_cache_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) i_cwf_chk (.*);

// File: tb/test_cwf_cache.sv
module test_cwf_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;

  typedef struct { bit w; logic [15:0] a; logic [31:0] d; } ent_t;
  ent_t        log_q[$];
  logic [31:0] bmem[int];
  logic [31:0] shadow[int];
  int          lat = 0;
  int          sz_at_ack;
  logic [31:0] got;

  cwf_cache i_cwf_cache (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] init_val(logic [15:0] a);
    return {a ^ 16'h3c3c, ~a};
  endfunction
  function automatic logic [15:0] mk(int t, int i, int o);
    return {8'(t), 6'(i), 2'(o)};
  endfunction
  function automatic logic [31:0] mem_val(logic [15:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : init_val(a);
  endfunction
  function automatic logic [31:0] exp_val(logic [15:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
  endfunction

  task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  // memory model: one word at a time, random 0..2 cycle latency
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req) begin
      if (lat == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
        mem_rdata <= mem_val(mem_addr);
        log_q.push_back('{mem_we, mem_addr, mem_wdata});
        lat = $urandom % 3;
      end else lat--;
    end
  end

  task automatic access(bit w, logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
    while (!ack) begin
      @(negedge clk);
      #1;
    end
    got = rdata;
    sz_at_ack = log_q.size();
    if (w) shadow[int'(a)] = d;
    @(posedge clk);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk(!ack && !mem_req, "R1 reset outputs", {30'd0, ack, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!ack && !mem_req, "R10 idle ack", {31'd0, ack}, 32'd0);

    // R3/R4: read miss on word 2 of line 10
    log_q.delete();
    access(1'b0, mk(1, 10, 2), '0);
    chk(got == init_val(mk(1, 10, 2)), "R4 critical data", got, init_val(mk(1, 10, 2)));
    chk(sz_at_ack == 1, "R4 ack on first beat", sz_at_ack, 1);
    chk(sz_at_ack >= 1 && log_q[0].a == mk(1, 10, 2), "R1 first access goes to memory",
        log_q[0].a, mk(1, 10, 2));
    // R5: same word again while refill still running
    access(1'b0, mk(1, 10, 2), '0);
    chk(sz_at_ack < 4, "R5 early hit during refill", sz_at_ack, 3);
    chk(got == init_val(mk(1, 10, 2)), "R5 early hit data", got, init_val(mk(1, 10, 2)));
    idle(20);
    chk(log_q.size() == 4, "R3 beat count", log_q.size(), 4);
    for (int i = 0; i < 4; i++)
      chk(!log_q[i].w && log_q[i].a == mk(1, 10, (2 + i) % 4), "R3 wrap order",
          log_q[i].a, mk(1, 10, (2 + i) % 4));

    // R2: hit on full line makes no memory traffic
    log_q.delete();
    access(1'b0, mk(1, 10, 0), '0);
    chk(got == init_val(mk(1, 10, 0)) && log_q.size() == 0, "R2 hit no traffic",
        got, init_val(mk(1, 10, 0)));

    // R5: word last in wrap order stalls until the refill ends
    idle(2);
    log_q.delete();
    access(1'b0, mk(1, 11, 1), '0);
    access(1'b0, mk(1, 11, 0), '0);
    chk(sz_at_ack == 4, "R5 stall on unfilled word", sz_at_ack, 4);
    chk(got == init_val(mk(1, 11, 0)), "R5 late word data", got, init_val(mk(1, 11, 0)));

    // R5: other line stalls during refill even if it would hit
    idle(20);
    log_q.delete();
    access(1'b0, mk(1, 12, 0), '0);
    access(1'b0, mk(1, 10, 3), '0);
    chk(sz_at_ack == 4, "R5 other line stalls", sz_at_ack, 4);
    chk(got == init_val(mk(1, 10, 3)), "R5 other line data", got, init_val(mk(1, 10, 3)));

    // R6: write hit
    idle(20);
    access(1'b1, mk(1, 10, 2), 32'hDEAD0001);
    access(1'b0, mk(1, 10, 2), '0);
    chk(got == 32'hDEAD0001, "R6 write hit readback", got, 32'hDEAD0001);

    // R8/R11: evict line 10 with one dirty word
    idle(2);
    log_q.delete();
    access(1'b0, mk(2, 10, 0), '0);
    chk(sz_at_ack == 2, "R11 stall through writeback", sz_at_ack, 2);
    idle(20);
    chk(log_q.size() == 5, "R8 one write plus refill", log_q.size(), 5);
    chk(log_q[0].w && log_q[0].a == mk(1, 10, 2) && log_q[0].d == 32'hDEAD0001,
        "R8 writeback word", log_q[0].d, 32'hDEAD0001);
    chk(!log_q[1].w && log_q[1].a == mk(2, 10, 0), "R8 read after write",
        log_q[1].a, mk(2, 10, 0));
    // R9: evict clean line, data came back from memory
    log_q.delete();
    access(1'b0, mk(1, 10, 2), '0);
    chk(got == 32'hDEAD0001, "R8 written data in memory", got, 32'hDEAD0001);
    idle(20);
    chk(log_q.size() == 4 && !log_q[0].w, "R9 clean eviction no write", log_q.size(), 4);

    // R7: write miss on word 3
    log_q.delete();
    access(1'b1, mk(3, 11, 3), 32'hBEEF0003);
    chk(sz_at_ack == 1, "R7 write acked on first beat", sz_at_ack, 1);
    idle(20);
    chk(log_q[0].a == mk(3, 11, 3) && !log_q[0].w, "R7 refill starts at written word",
        log_q[0].a, mk(3, 11, 3));
    access(1'b0, mk(3, 11, 3), '0);
    chk(got == 32'hBEEF0003, "R7 write merged", got, 32'hBEEF0003);
    access(1'b1, mk(3, 11, 0), 32'hBEEF0000);
    // R8: two dirty words, ascending order, clean ones skipped
    idle(2);
    log_q.delete();
    access(1'b0, mk(1, 11, 2), '0);
    idle(20);
    chk(log_q.size() == 6, "R8 only dirty words", log_q.size(), 6);
    chk(log_q[0].w && log_q[0].a == mk(3, 11, 0) && log_q[0].d == 32'hBEEF0000,
        "R8 first writeback", log_q[0].a, mk(3, 11, 0));
    chk(log_q[1].w && log_q[1].a == mk(3, 11, 3) && log_q[1].d == 32'hBEEF0003,
        "R8 second writeback", log_q[1].a, mk(3, 11, 3));

    // R2/R6: random mix over a few conflicting tags
    for (int n = 0; n < 3000; n++) begin
      automatic logic [15:0] a = mk($urandom % 4, $urandom % 4, $urandom % 4);
      automatic bit          w = $urandom % 2;
      automatic logic [31:0] d = $urandom;
      automatic logic [31:0] e = exp_val(a);
      access(w, a, d);
      if (!w) chk(got == e, "R2 R6 random read", got, e);
      if ($urandom % 8 == 0) idle($urandom % 4);
    end
    idle(20);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule